// File: doc/BRIEF.md
# Indirect Memory Access Controller

This block gives a host processor access to a large internal memory through two host-visible registers: a control register and a data register. The host writes the data register (for a write access), then writes the control register with a target address and a direction bit. That write starts one access. The block then checks the address against a memory bound. If the address is legal, the block runs the access on an internal memory port with a valid/ready handshake. It then reports the result in an error field, returns read data in the data register, and advances the stored address by one so that streaming through memory needs only repeated command writes.

The host must poll the BUSY bit and issue nothing new until it reads clear. Command writes and data-register writes that arrive while BUSY is set are dropped.

On the internal memory port the block is the initiator. While `mem_valid` is high it holds address, direction and write data steady, for as many cycles as the memory keeps `mem_ready` low. The memory may apply back-pressure for any number of cycles. The transfer completes in the cycle where `mem_valid` and `mem_ready` are both high. In that cycle the memory must present read data on `mem_rdata`.

Top module: `imc_top`

## Requirements
- R1: After reset, BUSY, ERROR, the address field, the direction bit and the data register are all 0, and `mem_valid` is low.
- R2: The control register layout is as follows. Bit 0 is the direction (1 = read, 0 = write). Bit 1 is BUSY (read-only). Bits 3:2 are ERROR. Bits starting at 8 (AW wide) are the address. During a request, `mem_we` is the inverse of the direction bit.
- R3: A control-register write (`host_we`=1, `host_sel`=0) accepted while idle makes BUSY read 1 from the next cycle.
- R4: An address not below MEM_DEPTH never reaches the memory port. BUSY drops after one cycle, ERROR becomes 1, and the address field keeps its value.
- R5: An out-of-range read clears the data register to 0.
- R6: For a legal address, `mem_valid` rises in the cycle after BUSY rises. While `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_we` and `mem_wdata` stay unchanged.
- R7: After the valid/ready handshake, BUSY reads 0 from the next cycle, ERROR becomes 0, and the address field grows by one.
- R8: On a read, `mem_rdata` from the handshake cycle is stored in the data register. On a write, `mem_wdata` equals the data register.
- R9: While BUSY is set, control-register writes and data-register writes change nothing.
- R10: A data-register write (`host_sel`=1) while idle stores the low DW bits. `host_rdata` shows the control register when `host_sel`=0 and the data register when `host_sel`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 1 | Register select: 0 control, 1 data |
| host_wdata | input | HW | Host write data |
| host_rdata | output | HW | Selected register contents |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts / completes request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Request address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, sampled at handshake |

## Verification
Two functions can meet in one cycle: a host register write and the completion of a pending memory transfer, where a new command lands in the same cycle as `mem_ready`. The bench provokes this by holding back `mem_ready` for several cycles. It writes the data register while the request waits, and then writes a new command exactly in the cycle it raises `mem_ready`. Both writes count as correct only if the final address is the old address plus one, the data register holds the memory's read data, and the memory saw the original address throughout.

// File: rtl/imc_pkg.sv
package imc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_REQ   = 2'd2
  } imc_state_t;

  localparam int DIR_BIT    = 0;
  localparam int BUSY_BIT   = 1;
  localparam int ERR_LSB    = 2;
  localparam int ERR_W      = 2;
  localparam int ADDR_LSB   = 8;

  localparam logic [ERR_W-1:0] ERR_NONE  = 2'd0;
  localparam logic [ERR_W-1:0] ERR_RANGE = 2'd1;
endpackage

// File: rtl/imc_bound.sv
module imc_bound #(
  parameter int AW        = 10,
  parameter int MEM_DEPTH = 800
) (
  input  logic [AW-1:0] addr,
  output logic          in_range
);
  localparam longint SPAN = longint'(1) << AW;

  generate
    if (MEM_DEPTH >= SPAN) begin : g_full
      assign in_range = 1'b1;
    end else begin : g_cmp
      localparam logic [AW-1:0] LIMIT = AW'(MEM_DEPTH);
      assign in_range = (addr < LIMIT);
    end
  endgenerate
endmodule

// File: rtl/imc_seq.sv
module imc_seq
  import imc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic in_range,
  input  logic mem_ready,
  output logic busy,
  output logic mem_valid,
  output logic fin_ok,
  output logic fin_err
);
  imc_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (accept) state_d = ST_CHECK;
      ST_CHECK: state_d = in_range ? ST_REQ : ST_IDLE;
      ST_REQ:   if (mem_ready) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign busy      = (state_q != ST_IDLE);
  assign mem_valid = (state_q == ST_REQ);
  assign fin_ok    = mem_valid && mem_ready;
  assign fin_err   = (state_q == ST_CHECK) && !in_range;

  // R6: a pending request waits for the memory
  a_r6_wait_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> mem_valid);

  // R7: handshake ends the busy phase
  a_r7_busy_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready) |=> !busy);

  // R4: failed bound check ends busy without a request
  a_r4_abort: assert property (@(posedge clk) disable iff (!rst_n)
    fin_err |=> (!busy && !mem_valid));
endmodule

// File: rtl/imc_regfile.sv
module imc_regfile
  import imc_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 16,
  parameter int HW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic             data_wr,
  input  logic [HW-1:0]    wdata,
  input  logic             fin_ok,
  input  logic             fin_err,
  input  logic [DW-1:0]    mem_rdata,
  output logic [AW-1:0]    addr_q,
  output logic             dir_q,
  output logic [ERR_W-1:0] err_q,
  output logic [DW-1:0]    data_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      dir_q  <= 1'b0;
      err_q  <= ERR_NONE;
      data_q <= '0;
    end else begin
      if (cmd_wr) begin
        addr_q <= wdata[ADDR_LSB +: AW];
        dir_q  <= wdata[DIR_BIT];
      end
      if (data_wr) data_q <= wdata[DW-1:0];
      if (fin_err) begin
        err_q <= ERR_RANGE;
        if (dir_q) data_q <= '0;
      end
      if (fin_ok) begin
        err_q  <= ERR_NONE;
        addr_q <= addr_q + AW'(1);
        if (dir_q) data_q <= mem_rdata;
      end
    end
  end

  // R7: address advances by one after a completed transfer
  a_r7_incr: assert property (@(posedge clk) disable iff (!rst_n)
    fin_ok |=> (addr_q == $past(addr_q) + AW'(1)));

  // R4: aborted command keeps its address
  a_r4_keep_addr: assert property (@(posedge clk) disable iff (!rst_n)
    fin_err |=> ($stable(addr_q) && err_q == ERR_RANGE));
endmodule

// File: rtl/imc_top.sv
module imc_top
  import imc_pkg::*;
#(
  parameter int AW        = 10,
  parameter int DW        = 16,
  parameter int HW        = 32,
  parameter int MEM_DEPTH = 800
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic          host_sel,
  input  logic [HW-1:0] host_wdata,
  output logic [HW-1:0] host_rdata,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  localparam int CTRL_USED = ADDR_LSB + AW;

  logic             busy, accept, data_wr, in_range, fin_ok, fin_err;
  logic [AW-1:0]    addr_q;
  logic             dir_q;
  logic [ERR_W-1:0] err_q;
  logic [DW-1:0]    data_q;
  logic [HW-1:0]    ctrl_view, data_view;

  assign accept  = host_we && !host_sel && !busy;
  assign data_wr = host_we &&  host_sel && !busy;

  imc_bound #(.AW(AW), .MEM_DEPTH(MEM_DEPTH)) u_bound (
    .addr     (addr_q),
    .in_range (in_range)
  );

  imc_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .in_range  (in_range),
    .mem_ready (mem_ready),
    .busy      (busy),
    .mem_valid (mem_valid),
    .fin_ok    (fin_ok),
    .fin_err   (fin_err)
  );

  imc_regfile #(.AW(AW), .DW(DW), .HW(HW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (accept),
    .data_wr   (data_wr),
    .wdata     (host_wdata),
    .fin_ok    (fin_ok),
    .fin_err   (fin_err),
    .mem_rdata (mem_rdata),
    .addr_q    (addr_q),
    .dir_q     (dir_q),
    .err_q     (err_q),
    .data_q    (data_q)
  );

  always_comb begin
    ctrl_view = '0;
    ctrl_view[DIR_BIT]              = dir_q;
    ctrl_view[BUSY_BIT]             = busy;
    ctrl_view[ERR_LSB +: ERR_W]     = err_q;
    ctrl_view[ADDR_LSB +: AW]       = addr_q;
    data_view = '0;
    data_view[DW-1:0]               = data_q;
  end

  assign host_rdata = host_sel ? data_view : ctrl_view;
  assign mem_we     = !dir_q;
  assign mem_addr   = addr_q;
  assign mem_wdata  = data_q;

  initial begin
    if (HW < CTRL_USED || HW < DW) $error("host width too small for fields");
  end

  // R3: an accepted command shows BUSY next cycle
  a_r3_busy_set: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> host_rdata[BUSY_BIT] || host_sel);

  // R4: no request leaves the block for an illegal address
  a_r4_bound: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> in_range);

  // R6: request fields hold while the memory stalls
  a_r6_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=>
      ($stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R9: host writes during a stalled request change nothing
  a_r9_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready && host_we) |=>
      ($stable(ctrl_view) && $stable(data_view)));
endmodule

// File: tb/sim_imc_top.sv
module sim_imc_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10, DW = 16, HW = 32, DEPTH = 800;
  localparam int WATCHDOG = 20000;

  typedef struct packed {
    logic          dir;
    logic [AW-1:0] addr;
    logic [DW-1:0] wd;
    logic [DW-1:0] rd;
    logic [3:0]    waits;
    logic [1:0]    exp_err;
    logic [AW-1:0] exp_addr;
    logic [DW-1:0] exp_data;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 10'd5,    16'h1234, 16'h0000, 4'd0, 2'd0, 10'd6,    16'h1234},
    '{1'b1, 10'd6,    16'h0000, 16'hBEEF, 4'd3, 2'd0, 10'd7,    16'hBEEF},
    '{1'b1, 10'd900,  16'h0000, 16'h0000, 4'd0, 2'd1, 10'd900,  16'h0000},
    '{1'b0, 10'd800,  16'h5555, 16'h0000, 4'd0, 2'd1, 10'd800,  16'h5555},
    '{1'b1, 10'd799,  16'h0000, 16'h0F0F, 4'd1, 2'd0, 10'd800,  16'h0F0F},
    '{1'b0, 10'd1023, 16'h6666, 16'h0000, 4'd0, 2'd1, 10'd1023, 16'h6666},
    '{1'b0, 10'd0,    16'hA5A5, 16'h0000, 4'd2, 2'd0, 10'd1,    16'hA5A5}
  };

  logic clk = 0, rst_n = 0;
  logic host_we = 0, host_sel = 0, mem_ready = 0;
  logic [HW-1:0] host_wdata = '0, host_rdata;
  logic mem_valid, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata = '0;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  imc_top #(.AW(AW), .DW(DW), .HW(HW), .MEM_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [HW-1:0] cmd_word(input logic [AW-1:0] a, input logic d);
    logic [HW-1:0] w;
    w = '0;
    w[8 +: AW] = a;
    w[0] = d;
    return w;
  endfunction

  task automatic host_write(input logic sel, input logic [HW-1:0] w);
    @(negedge clk);
    host_we = 1; host_sel = sel; host_wdata = w;
    @(negedge clk);
    host_we = 0; host_sel = 0;
  endtask

  // Issue one command and serve the memory side; intr enables same-cycle host writes
  task automatic run_cmd(input logic dir, input logic [AW-1:0] a, input logic [DW-1:0] rd,
                         input int waits, input bit intr, output bit seen);
    int w = 0, it = 0;
    bit done = 0, hs = 0;
    seen = 0;
    @(negedge clk);
    host_we = 1; host_sel = 0; host_wdata = cmd_word(a, dir);
    while (!done && it < 100) begin
      @(negedge clk);
      host_we = 0; host_sel = 0; mem_ready = 0;
      #1;
      if (it == 0)
        chk(host_rdata[1] == 1'b1, "R3 busy after command", 32'(host_rdata[1]), 32'd1);
      if (!host_rdata[1]) done = 1;
      else begin
        if (hs) chk(1'b0, "R7 busy clears after handshake", 32'd1, 32'd0);
        if (mem_valid) begin
          if (!seen)
            chk(it == 1, "R6 request one cycle after busy", 32'(it), 32'd1);
          seen = 1;
          chk(mem_addr == a, "R6 request address held", 32'(mem_addr), 32'(a));
          chk(mem_we == !dir, "R2 direction on memory port", 32'(mem_we), 32'(!dir));
          if (w == waits) begin
            mem_ready = 1; mem_rdata = rd; hs = 1;
          end
          if (intr && w == 1) begin
            host_we = 1; host_sel = 1; host_wdata = 32'h7777;
          end
          if (intr && w == waits) begin
            host_we = 1; host_sel = 0; host_wdata = cmd_word(10'd3, 1'b0);
          end
          w++;
        end
      end
      it++;
    end
  endtask

  task automatic read_regs(output logic [HW-1:0] c, output logic [HW-1:0] d);
    @(negedge clk);
    host_sel = 0; #1 c = host_rdata;
    host_sel = 1; #1 d = host_rdata;
    host_sel = 0;
  endtask

  initial begin
    logic [HW-1:0] c, d;
    bit seen;
    repeat (3) @(negedge clk);
    #1;
    chk(host_rdata == '0 && mem_valid == 0, "R1 reset state", host_rdata, 32'd0);
    rst_n = 1;
    read_regs(c, d);
    chk(c == '0 && d == '0, "R1 registers zero after reset", c | d, 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (!VEC[i].dir) host_write(1'b1, 32'(VEC[i].wd));
      run_cmd(VEC[i].dir, VEC[i].addr, VEC[i].rd, int'(VEC[i].waits), 1'b0, seen);
      read_regs(c, d);
      chk(seen == (VEC[i].exp_err == 0), "R4 memory request only in range", 32'(seen), 32'(VEC[i].exp_err == 0));
      chk(c[3:2] == VEC[i].exp_err, "R7 R4 error field", 32'(c[3:2]), 32'(VEC[i].exp_err));
      chk(c[8 +: AW] == VEC[i].exp_addr, "R7 R4 address after command", 32'(c[8 +: AW]), 32'(VEC[i].exp_addr));
      chk(d[DW-1:0] == VEC[i].exp_data, "R8 R5 R10 data register", d, 32'(VEC[i].exp_data));
      chk(c[1] == 0 && c[0] == VEC[i].dir, "R2 direction bit and idle busy", c, 32'(VEC[i].dir));
    end

    // R10: data write while idle, read through select
    host_write(1'b1, 32'hABCD_1357);
    read_regs(c, d);
    chk(d == 32'h0000_1357, "R10 data register low bits", d, 32'h0000_1357);

    // R9: data write and command write while a request stalls, command on ready cycle
    run_cmd(1'b1, 10'd10, 16'hC0DE, 4, 1'b1, seen);
    read_regs(c, d);
    chk(c[8 +: AW] == 10'd11, "R9 command during busy ignored", 32'(c[8 +: AW]), 32'd11);
    chk(c[0] == 1'b1, "R9 direction unchanged", 32'(c[0]), 32'd1);
    chk(d[DW-1:0] == 16'hC0DE, "R9 data write during busy ignored", d, 32'h0000C0DE);

    // R8: write data reaches memory port
    host_write(1'b1, 32'h0000_2468);
    @(negedge clk); #1;
    chk(mem_wdata == 16'h2468, "R8 write data on memory port", 32'(mem_wdata), 32'h2468);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule